// File: doc/BRIEF.md
# Stack Pointer Register with Write-Triggered Interrupt Shield

This block stores a 16-bit stack pointer that software updates one byte at a time through two I/O addresses: one for the low byte and one for the high byte. Because the two bytes are written in separate instructions, an interrupt taken between them would see a half-updated pointer. The block closes that gap by itself. Software does not have to clear the global interrupt enable around the update.

A write to the low byte opens a short shield. While the shield is open, the interrupt request passed to the core is held low. The shield closes after four clock cycles, or earlier at the next I/O write to any address, which is normally the high-byte write. Requests that arrive during the shield are not dropped: the incoming request is a level, so it reaches the core as soon as the shield closes.

A small state machine controls the shield. It has two states. In `ST_OPEN`, requests pass through. In `ST_SHIELD`, requests are blocked. The transitions are:

- `T_ARM`: a low-byte write in `ST_OPEN` moves to `ST_SHIELD` and loads the cycle counter.
- `T_REARM`: a low-byte write in `ST_SHIELD` reloads the counter and stays in `ST_SHIELD`.
- `T_CUT`: any other I/O write in `ST_SHIELD` returns to `ST_OPEN`.
- `T_EXPIRE`: the counter reaching zero in `ST_SHIELD` returns to `ST_OPEN`.
- `T_TICK`: a cycle with no I/O write in `ST_SHIELD` lowers the counter by one.

Top module: `sp_irq_shield`

## Requirements
- R1: On the clock edge that samples `io_we` high, a write to address 0x3D loads `io_wdata` into `sp_value[7:0]`, and a write to address 0x3E loads it into `sp_value[15:8]`. The other byte keeps its value.
- R2: When `io_we` is low, or the address is neither 0x3D nor 0x3E, `sp_value` does not change.
- R3: A write to 0x3D, with no further I/O write, holds `irq_out` low for exactly the 4 cycles that follow the write edge. In the 5th cycle, `irq_out` again follows `irq_in`.
- R4: While the shield is open, an I/O write to any address other than 0x3D closes it at that edge. From the next cycle on, `irq_out` follows `irq_in`.
- R5: A write to 0x3D while the shield is open restarts the 4-cycle count from that edge.
- R6: A write to 0x3E while no shield is open does not open one.
- R7: While no shield is open, `irq_out` equals `irq_in` in the same cycle. A request held high through the shield shows on `irq_out` in the first cycle after the shield closes.
- R8: After reset, `sp_value` is 0 and no shield is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | 6 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| irq_in | input | 1 | Incoming interrupt request (level) |
| sp_value | output | 16 | Current stack pointer |
| irq_out | output | 1 | Interrupt request to the core, blocked while the shield is open |

## Verification
The main pattern is a low-byte write followed by the high-byte write at several distances: 1 to 3 cycles, exactly 4 cycles, and never. Comparing these separates early closing by a write from closing by expiry, and shows whether the count is off by one. Further sequences cover:

- Repeated low-byte writes, to show restart apart from a plain extension.
- A high-byte write alone, to show it does not open a shield.
- Writes to an unrelated address, which close the shield but must leave the pointer unchanged.

Random mixes of the three kinds of address, with `irq_in` toggling, are checked cycle by cycle against a model in the bench.

// File: rtl/sp_shield_pkg.sv
package sp_shield_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_SHIELD = 1'b1
    } shield_state_t;
endpackage

// File: rtl/sp_byte_regs.sv
module sp_byte_regs #(
    parameter int ADDR_W  = 6,
    parameter int BYTE_W  = 8,
    parameter int LO_ADDR = 'h3D,
    parameter int HI_ADDR = 'h3E
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_we,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [BYTE_W-1:0]   io_wdata,
    output logic [2*BYTE_W-1:0] sp_value
);
    localparam int SP_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              lo_hit, hi_hit;

    assign lo_hit   = io_we && (io_addr == ADDR_W'(LO_ADDR));
    assign hi_hit   = io_we && (io_addr == ADDR_W'(HI_ADDR));
    assign sp_value = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_hit) lo_q <= io_wdata;
            if (hi_hit) hi_q <= io_wdata;
        end
    end

    // R1: a low-byte write lands in the low byte and leaves the high byte alone.
    a_r1_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        lo_hit |=> (sp_value[BYTE_W-1:0] == $past(io_wdata))
                && (sp_value[SP_W-1:BYTE_W] == $past(sp_value[SP_W-1:BYTE_W])));

    // R1: a high-byte write lands in the high byte and leaves the low byte alone.
    a_r1_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        hi_hit |=> (sp_value[SP_W-1:BYTE_W] == $past(io_wdata))
                && (sp_value[BYTE_W-1:0] == $past(sp_value[BYTE_W-1:0])));

    // R2: without a write to either byte address, the pointer holds its value.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_hit || hi_hit) |=> $stable(sp_value));
endmodule

// File: rtl/sp_shield_fsm.sv
module sp_shield_fsm
    import sp_shield_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int LO_ADDR     = 'h3D,
    parameter int MASK_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              shield
);
    localparam int CNT_W = $clog2(MASK_CYCLES + 1);

    shield_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lo_wr, other_wr;

    assign lo_wr    = io_we && (io_addr == ADDR_W'(LO_ADDR));
    assign other_wr = io_we && !lo_wr;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OPEN: begin
                if (lo_wr) begin                    // T_ARM
                    state_d = ST_SHIELD;
                    cnt_d   = CNT_W'(MASK_CYCLES - 1);
                end
            end
            ST_SHIELD: begin
                if (lo_wr) begin                    // T_REARM
                    cnt_d = CNT_W'(MASK_CYCLES - 1);
                end else if (other_wr) begin        // T_CUT
                    state_d = ST_OPEN;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin     // T_EXPIRE
                    state_d = ST_OPEN;
                end else begin                      // T_TICK
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_OPEN;
                cnt_d   = '0;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        shield = (state_q == ST_SHIELD);
    end

    // R3: a low-byte write opens the shield on the next cycle.
    a_r3_lo_opens: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> shield);

    // R4: any other write while shielded closes the shield.
    a_r4_write_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (shield && other_wr) |=> !shield);

    // R6: a write that is not to the low byte never opens a shield.
    a_r6_hi_no_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!shield && other_wr) |=> !shield);

    // R5: a re-arm reloads the full count.
    a_r5_rearm_full: assert property (@(posedge clk) disable iff (!rst_n)
        (shield && lo_wr) |=> (cnt_q == CNT_W'(MASK_CYCLES - 1)));
endmodule

// File: rtl/sp_irq_shield.sv
module sp_irq_shield #(
    parameter int ADDR_W      = 6,
    parameter int BYTE_W      = 8,
    parameter int LO_ADDR     = 'h3D,
    parameter int HI_ADDR     = 'h3E,
    parameter int MASK_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_we,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [BYTE_W-1:0]   io_wdata,
    input  logic                irq_in,
    output logic [2*BYTE_W-1:0] sp_value,
    output logic                irq_out
);
    logic shield;

    sp_byte_regs #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_we    (io_we),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .sp_value (sp_value)
    );

    sp_shield_fsm #(
        .ADDR_W      (ADDR_W),
        .LO_ADDR     (LO_ADDR),
        .MASK_CYCLES (MASK_CYCLES)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_we   (io_we),
        .io_addr (io_addr),
        .shield  (shield)
    );

    assign irq_out = irq_in && !shield;

    // R7: while shielded the core sees no request; otherwise it sees the input.
    a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        shield |-> !irq_out);
    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !shield |-> (irq_out == irq_in));
endmodule

// File: tb/sp_irq_shield_tb.sv
module sp_irq_shield_tb_top;
    localparam logic [5:0] LO = 6'h3D;
    localparam logic [5:0] HI = 6'h3E;
    localparam logic [5:0] XX = 6'h10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_we;
    logic [5:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        irq_in;
    logic [15:0] sp_value;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_sp;
    int          m_left;
    bit          done = 0;

    always #4 clk = ~clk;

    sp_irq_shield dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_we    (io_we),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .irq_in   (irq_in),
        .sp_value (sp_value),
        .irq_out  (irq_out)
    );

    // Model of the pointer after one write, from R1/R2.
    function automatic logic [15:0] exp_sp(logic [15:0] sp, logic we,
                                           logic [5:0] a, logic [7:0] d);
        if (we && a == LO) return {sp[15:8], d};
        if (we && a == HI) return {d, sp[7:0]};
        return sp;
    endfunction

    // Model of the remaining shield cycles, from R3/R4/R5/R6.
    function automatic int exp_left(int left, logic we, logic [5:0] a);
        if (we && a == LO) return 4;
        if (we) return 0;
        if (left > 0) return left - 1;
        return 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass, then compare.
    task automatic step(logic we, logic [5:0] a, logic [7:0] d, logic irq,
                        string tag);
        io_we = we; io_addr = a; io_wdata = d; irq_in = irq;
        @(posedge clk);
        m_sp   = exp_sp(m_sp, we, a, d);
        m_left = exp_left(m_left, we, a);
        @(negedge clk);
        io_we = 1'b0;
        #1;
        check({tag, " sp"}, {16'h0, sp_value}, {16'h0, m_sp});
        check({tag, " irq"}, {31'h0, irq_out}, {31'h0, irq && (m_left == 0)});
    endtask

    task automatic idle(int n, logic irq, string tag);
        for (int i = 0; i < n; i++) step(1'b0, XX, 8'h00, irq, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; io_we = 1'b0; io_addr = '0; io_wdata = '0; irq_in = 1'b1;
        m_sp = '0; m_left = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state, with a request passing straight through.
        check("R8 sp", {16'h0, sp_value}, 32'h0);
        check("R8 irq", {31'h0, irq_out}, 32'h1);

        // R1: write each byte.
        step(1'b1, LO, 8'hA5, 1'b0, "R1");
        idle(5, 1'b0, "R1");
        step(1'b1, HI, 8'h3C, 1'b0, "R1");
        // R6: the high-byte write alone does not block the request.
        step(1'b0, XX, 8'h00, 1'b1, "R6");

        // R3: full window, then the request held high comes through (R7).
        step(1'b1, LO, 8'h11, 1'b1, "R3");
        idle(5, 1'b1, "R7");

        // R4: high-byte write closes the window after 1, 2, 3 and 4 cycles.
        for (int gap = 0; gap < 4; gap++) begin
            step(1'b1, LO, 8'(gap), 1'b1, "R4");
            idle(gap, 1'b1, "R4");
            step(1'b1, HI, 8'(gap + 8'h40), 1'b1, "R4");
            idle(2, 1'b1, "R4");
        end

        // R2: a write to another address closes the window, pointer unchanged.
        step(1'b1, LO, 8'h77, 1'b1, "R2");
        step(1'b1, XX, 8'hEE, 1'b1, "R2");
        idle(2, 1'b1, "R2");

        // R5: re-arm in the window restarts the count.
        step(1'b1, LO, 8'h01, 1'b1, "R5");
        idle(2, 1'b1, "R5");
        step(1'b1, LO, 8'h02, 1'b1, "R5");
        idle(5, 1'b1, "R5");

        // Random mix of addresses and request levels.
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [5:0] a;
            r = $urandom % 8;
            a = (r < 2) ? LO : (r < 4) ? HI : XX;
            step(($urandom % 3) == 0, a, 8'($urandom), 1'($urandom), "R7 rand");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule